// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block gathers requests from eight hardware interrupt lines, filters them through a mask that software writes, and selects the most urgent one. When a selection exists it raises a single interrupt output toward the processor. When the processor acknowledges, the block returns a vector byte equal to a programmed base plus the line number, and records the line as in service.

Software reaches the block over a byte-wide register bus with a one-bit address: address 0 is the command port and address 1 is the data port. A command write with bit 4 set begins a fixed configuration sequence. Later data writes then deliver the vector base, an optional cascade byte and an optional mode byte, in that order. Once the sequence is complete, data writes load the mask. Each serviced interrupt is retired by writing an end-of-interrupt command, unless automatic retirement was selected during configuration. The cascade byte is kept so it can be read back, but it drives no pins.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF on a data-port read, `cpu_int` is low, and until a configuration sequence starts, data-port writes and line activity have no effect.
- R2: A command write with bit 4 set clears the mask to 0x00, clears the in-service state and pending requests, and keeps `cpu_int` low until the sequence completes. Line edges seen during the sequence are dropped.
- R3: In that first command byte, bit 0 set means a mode byte will follow, bit 1 set means single mode (no cascade byte), and bit 3 set means level-sensitive lines instead of rising-edge lines.
- R4: The first data write after the start is the vector base. In cascade mode the next data write is the cascade byte, which a command-port read returns. If a mode byte was requested, the next data write is that byte, and its bit 1 selects automatic retirement. Otherwise the block enters normal operation after the last required byte.
- R5: Data writes made during the configuration sequence never reach the mask.
- R6: In normal operation a data write loads the mask and a data-port read returns it. A 1 in bit n disables line n.
- R7: In edge mode a rising edge on a line latches a request that stays pending after the line falls. The request clears when it is acknowledged, and a line that stays high raises no second request.
- R8: In level mode the request follows the line level, so a line that drops before acknowledge withdraws its request.
- R9: Line 0 has the highest priority and line 7 the lowest. When `cpu_ack` is high while `cpu_int` is high, `bus_rdata` shows base + winning line in that same cycle, and that line enters service.
- R10: A line in service holds back requests of equal or lower priority. A higher-priority unmasked request still raises `cpu_int`.
- R11: A command write of 0x20 in normal operation removes the highest-priority line from service.
- R12: With automatic retirement, no line is ever held in service, so later requests are delivered without a retiring command.
- R13: `cpu_ack` while `cpu_int` is low changes neither the in-service nor the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Vector during acknowledge; otherwise mask (address 1) or cascade byte (address 0) |
| irq_lines | input | 8 | Hardware interrupt lines |
| cpu_ack | input | 1 | Single-cycle interrupt acknowledge |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
A corrupted in-service register shows up on the first acknowledge or retiring command that follows it. Either `cpu_int` stays low when a pending line should get through, or it rises for a line that ought to be held back, one clock after the bad update. A mistake in the configuration sequencer moves every later data write to the wrong place. That is visible on the next mask or cascade read-back, and as a vector offset by the wrong base. Faults in edge latching appear as a missing or duplicated vector at the next acknowledge.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_BASE   = 3'd1,
    ST_CASC   = 3'd2,
    ST_MODE   = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

  localparam int CFG_NEED_MODE_BIT = 0;
  localparam int CFG_SINGLE_BIT    = 1;
  localparam int CFG_LEVEL_BIT     = 3;
  localparam int CFG_START_BIT     = 4;
  localparam int MODE_AUTO_BIT     = 1;
  localparam logic [7:0] RETIRE_CODE = 8'h20;
endpackage

// File: rtl/vic_init_seq.sv
`timescale 1ns/1ps
module vic_init_seq
  import vic_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          run,
  output logic          init_start,
  output logic          retire_cmd,
  output logic          level_mode,
  output logic          auto_eoi,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_cfg,
  output logic [N-1:0]  mask
);
  seq_state_e    st_q, st_d;
  logic          need_mode_q, need_mode_d;
  logic          single_q, single_d;
  logic          level_q, level_d;
  logic          auto_q, auto_d;
  logic [DW-1:0] base_q, base_d;
  logic [DW-1:0] casc_q, casc_d;
  logic [N-1:0]  mask_q, mask_d;
  logic          cmd_wr, dat_wr;

  assign cmd_wr     = wr & ~addr;
  assign dat_wr     = wr & addr;
  assign init_start = cmd_wr & wdata[CFG_START_BIT];
  assign retire_cmd = cmd_wr & (st_q == ST_RUN) & (wdata == DW'(RETIRE_CODE));

  always_comb begin
    st_d        = st_q;
    need_mode_d = need_mode_q;
    single_d    = single_q;
    level_d     = level_q;
    auto_d      = auto_q;
    base_d      = base_q;
    casc_d      = casc_q;
    mask_d      = mask_q;
    if (init_start) begin
      st_d        = ST_BASE;
      need_mode_d = wdata[CFG_NEED_MODE_BIT];
      single_d    = wdata[CFG_SINGLE_BIT];
      level_d     = wdata[CFG_LEVEL_BIT];
      auto_d      = 1'b0;
      mask_d      = '0;
    end else if (dat_wr) begin
      unique case (st_q)
        ST_BASE: begin
          base_d = wdata;
          if (!single_q)        st_d = ST_CASC;
          else if (need_mode_q) st_d = ST_MODE;
          else                  st_d = ST_RUN;
        end
        ST_CASC: begin
          casc_d = wdata;
          st_d   = need_mode_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          auto_d = wdata[MODE_AUTO_BIT];
          st_d   = ST_RUN;
        end
        ST_RUN:  mask_d = wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_UNINIT;
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
      level_q     <= 1'b0;
      auto_q      <= 1'b0;
      base_q      <= '0;
      casc_q      <= '0;
      mask_q      <= '1;
    end else begin
      st_q        <= st_d;
      need_mode_q <= need_mode_d;
      single_q    <= single_d;
      level_q     <= level_d;
      auto_q      <= auto_d;
      base_q      <= base_d;
      casc_q      <= casc_d;
      mask_q      <= mask_d;
    end
  end

  assign run        = (st_q == ST_RUN);
  assign level_mode = level_q;
  assign auto_eoi   = auto_q;
  assign vec_base   = base_q;
  assign casc_cfg   = casc_q;
  assign mask       = mask_q;

  // R2
  init_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (!run && mask == '0));
endmodule

// File: rtl/vic_req_latch.sv
`timescale 1ns/1ps
module vic_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic         level,
  input  logic         run,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q, irr_q, irr_d, new_rise;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign new_rise[i] = lines[i] & ~prev_q[i] & ~irr_q[i];
    assign irr_d[i] = !run  ? 1'b0 :
                      level ? lines[i] :
                      ((irr_q[i] | (lines[i] & ~prev_q[i])) & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= lines;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;

  // R7
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !level) |=> ((irr & $past(new_rise)) == $past(new_rise)));
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  isr,
  output logic [N-1:0]  win_oh,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  isr_top_oh,
  output logic          any
);
  logic [N-1:0] allow, elig;

  assign isr_top_oh = isr & (~isr + N'(1));
  assign allow      = (isr == '0) ? {N{1'b1}} : (isr_top_oh - N'(1));
  assign elig       = pend & allow;
  assign win_oh     = elig & (~elig + N'(1));
  assign any        = |elig;

  always_comb begin
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (win_oh[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  irq_lines,
  input  logic          cpu_ack,
  output logic          cpu_int
);
  localparam int IW = $clog2(N);

  logic          run, init_start, retire_cmd, level_mode, auto_eoi, any, take;
  logic [DW-1:0] vec_base, casc_cfg, vec;
  logic [N-1:0]  mask, irr, pend, win_oh, isr_top_oh, req_clr;
  logic [N-1:0]  isr_q, isr_d;
  logic [IW-1:0] win_idx;

  vic_init_seq #(.DW(DW), .N(N)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .run(run), .init_start(init_start), .retire_cmd(retire_cmd),
    .level_mode(level_mode), .auto_eoi(auto_eoi), .vec_base(vec_base),
    .casc_cfg(casc_cfg), .mask(mask)
  );

  vic_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .level(level_mode),
    .run(run), .clr(req_clr), .irr(irr)
  );

  assign pend = irr & ~mask;

  vic_prio #(.N(N), .IW(IW)) u_pick (
    .pend(pend), .isr(isr_q), .win_oh(win_oh), .win_idx(win_idx),
    .isr_top_oh(isr_top_oh), .any(any)
  );

  assign cpu_int = run & any;
  assign take    = cpu_ack & cpu_int;
  assign req_clr = (take && !level_mode) ? win_oh : '0;
  assign vec     = vec_base + DW'(win_idx);

  always_comb begin
    isr_d = isr_q;
    if (init_start || !run) begin
      isr_d = '0;
    end else begin
      if (retire_cmd)          isr_d = isr_d & ~isr_top_oh;
      if (take && !auto_eoi)   isr_d = isr_d | win_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  always_comb begin
    if (take)          bus_rdata = vec;
    else if (bus_addr) bus_rdata = DW'(mask);
    else               bus_rdata = casc_cfg;
  end

  // R12
  auto_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi |-> (isr_q == '0));

  // R10
  nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_int && isr_q != '0) |-> (win_oh < isr_top_oh));

  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((win_oh & mask) == '0));

  // R9
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !auto_eoi && !retire_cmd && !init_start) |=>
      (isr_q == ($past(isr_q) | $past(win_oh))));

  // R13
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_int && run && !retire_cmd && !init_start) |=> $stable(isr_q));

  // R11
  retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cmd && !take && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  localparam int N  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [N-1:0]  irq_lines = '0;
  logic          cpu_ack = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          cpu_int;

  int            n_vec = 0;
  int            n_bad = 0;
  logic [DW-1:0] exp_q[$];
  logic          expect_vec = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.N(N), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .cpu_ack(cpu_ack), .cpu_int(cpu_int)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [DW-1:0] e);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, e);
    step();
  endtask

  task automatic int_chk(input string tag, input logic e);
    @(negedge clk);
    check(tag, DW'(cpu_int), DW'(e));
    step();
  endtask

  task automatic set_lines(input logic [N-1:0] v);
    irq_lines = v;
    step();
  endtask

  // driver: queue the expected vector, then pulse acknowledge
  task automatic take(input logic [DW-1:0] v);
    exp_q.push_back(v);
    expect_vec = 1'b1; cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0; expect_vec = 1'b0;
  endtask

  // monitor: compare the vector shown during acknowledge (R9)
  always @(negedge clk) begin
    if (cpu_ack && expect_vec) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R9 vector: got %h expected none", bus_rdata);
      end else begin
        check("R9 vector", bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state and inertness before configuration
    int_chk("R1 int after reset", 1'b0);
    set_lines(8'h02);
    int_chk("R1 line ignored before config", 1'b0);
    wr(1'b1, 8'h00);
    rd_chk("R1 mask after reset", 1'b1, 8'hFF);
    set_lines(8'h00);

    // edge, cascade, mode byte requested (normal retirement)
    wr(1'b0, 8'h11);
    rd_chk("R2 mask cleared by start", 1'b1, 8'h00);
    wr(1'b1, 8'h20);
    rd_chk("R5 base write not in mask", 1'b1, 8'h00);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    rd_chk("R4 cascade byte readback", 1'b0, 8'h04);
    rd_chk("R5 mask untouched by sequence", 1'b1, 8'h00);

    // R6 mask load and effect
    wr(1'b1, 8'hFD);
    rd_chk("R6 mask readback", 1'b1, 8'hFD);
    set_lines(8'h03);
    int_chk("R6 unmasked line raises int", 1'b1);
    take(8'h21);
    int_chk("R10 masked line0 stays silent", 1'b0);
    wr(1'b1, 8'h00);
    int_chk("R10 higher line preempts", 1'b1);
    take(8'h20);
    int_chk("R10 nothing left", 1'b0);
    wr(1'b0, 8'h20);
    int_chk("R11 retire leaves no pending", 1'b0);
    set_lines(8'h01);
    set_lines(8'h03);
    int_chk("R10 equal priority held back", 1'b0);
    wr(1'b0, 8'h20);
    int_chk("R11 retire releases line1", 1'b1);
    take(8'h21);
    wr(1'b0, 8'h20);
    int_chk("R7 steady high gives no new request", 1'b0);

    // R9 priority between lines 3 and 5
    set_lines(8'h2B);
    int_chk("R9 int for lines 3 and 5", 1'b1);
    take(8'h23);
    int_chk("R10 lower line5 held back", 1'b0);
    wr(1'b0, 8'h20);
    int_chk("R11 line5 released", 1'b1);
    take(8'h25);
    wr(1'b0, 8'h20);

    // R7 request held after line falls
    set_lines(8'h00);
    set_lines(8'h80);
    set_lines(8'h00);
    int_chk("R7 held after line fell", 1'b1);
    take(8'h27);
    wr(1'b0, 8'h20);
    int_chk("R7 cleared by acknowledge", 1'b0);

    // R13 stray acknowledge
    cpu_ack = 1'b1;
    step();
    cpu_ack = 1'b0;
    set_lines(8'h10);
    int_chk("R13 stray ack left state alone", 1'b1);
    take(8'h24);
    wr(1'b0, 8'h20);
    set_lines(8'h00);

    // R3 level, single mode, no mode byte
    wr(1'b1, 8'h55);
    wr(1'b0, 8'h1A);
    rd_chk("R2 restart clears mask", 1'b1, 8'h00);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'hF0);
    rd_chk("R3 single mode skips cascade byte", 1'b1, 8'hF0);
    set_lines(8'h08);
    int_chk("R8 level request", 1'b1);
    set_lines(8'h00);
    int_chk("R8 level withdrawn", 1'b0);
    set_lines(8'h04);
    take(8'h42);
    int_chk("R10 in service blocks same line", 1'b0);
    wr(1'b0, 8'h20);
    int_chk("R8 level still high re-requests", 1'b1);
    take(8'h42);
    wr(1'b0, 8'h20);
    set_lines(8'h00);

    // R12 automatic retirement
    wr(1'b0, 8'h13);
    set_lines(8'h01);
    int_chk("R2 int low during sequence", 1'b0);
    wr(1'b1, 8'h60);
    wr(1'b1, 8'h02);
    int_chk("R2 edge during sequence dropped", 1'b0);
    set_lines(8'h00);
    set_lines(8'h01);
    int_chk("R12 line0 request", 1'b1);
    take(8'h60);
    set_lines(8'h03);
    int_chk("R12 next request without retire", 1'b1);
    take(8'h61);
    set_lines(8'h00);

    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 queue: got %0d left expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule